// File: doc/BRIEF.md
# Double-Buffered Phase Core

This block is the phase-generation heart of a direct digital synthesizer. A 40-bit staging register is filled over a write strobe, either eight bits per strobe or one bit per strobe. The staging register has no effect on the output until an update strobe copies it into a working register. The working register holds a 32-bit frequency step and a 5-bit phase offset. On every system clock a 32-bit accumulator advances by the frequency step. The registered output is the accumulator with the offset added to its top five bits, which shifts the phase in steps of 1/32 of a cycle (11.25 degrees).

Double buffering lets several cores that share one clock be staged one at a time and then switched together by a single common update strobe. A common reset puts every core at phase zero. Reset clears the accumulator, the working register and the output. It leaves the staging register as it was, so firmware must rewrite the staging register before it issues an update. All strobes are sampled on the system clock, and only their rising edges act.

The working word layout is: frequency step in bits [31:0], three spare control bits in [34:32], and the phase offset in [39:35].

Top module: `dds_phase_core`

## Requirements
- R1: While reset is high at a clock edge, the accumulator, the working register and `phase_out` are cleared to zero. With no update after reset, `phase_out` stays 0.
- R2: With `load_sel` = 0 (byte mode), each write-strobe rising edge moves the staging register 8 bits toward the LSB and places `din` in bits [39:32]. After five writes, the last byte is in [39:32] (offset in [39:35]) and the first byte is in [7:0].
- R3: With `load_sel` = 1 (bit mode), each write-strobe rising edge moves the staging register 1 bit toward the LSB and places `din[0]` in bit 39. After forty writes, the first bit is in bit 0. `din[7:1]` are ignored.
- R4: A write strobe held high for several cycles shifts the staging register only once.
- R5: At the first clock edge that samples `upd_stb` high after it was low, the working register takes the staging register. At edge U+n (n ≥ 1) after that edge U, `phase_out` equals the phase of accumulator value A0 + (n−1)·F, using the new offset, where F is the new frequency step and A0 is the accumulator value after edge U.
- R6: An update strobe held high causes exactly one transfer. Staging writes made while it is held do not reach the working register.
- R7: The accumulator adds the frequency step on every clock, modulo 2^32.
- R8: `phase_out[31:27]` equals (accumulator[31:27] + offset) mod 32, and `phase_out[26:0]` equals accumulator[26:0]. Both use the values from before the same clock edge.
- R9: Reset leaves the staging register unchanged. An update after reset, with no rewrite, transfers the word that was staged before reset.
- R10: Control bits [34:32] have no effect on `phase_out`.
- R11: Staging writes without an update strobe do not change the output sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | Write strobe; each rising edge shifts the staging register |
| load_sel | input | 1 | 0 selects byte loading, 1 selects bit loading on din[0] |
| din | input | 8 | Load data |
| upd_stb | input | 1 | Update strobe; a rising edge moves the staging word to the working register |
| phase_out | output | 32 | Registered phase word with the offset applied |

## Verification
A wrong staging-register order or an extra shift changes the frequency step, the offset, or both. The error appears at `phase_out` from the second edge after the update, and it grows linearly after that. An offset that is wrong or placed in the wrong bits shows up in `phase_out[31:27]` on the first edge after the update. A missed or repeated transfer, or a working register that follows the staging register without an update, shows a slope change at the moment of the stray write. The bench samples at exact cycle counts from the update edge, so each of these faults gives a mismatch within a few cycles.

// File: rtl/dds_core_pkg.sv
package dds_core_pkg;
  localparam int FTW_W  = 32;
  localparam int OFF_W  = 5;
  localparam int CTRL_W = 3;
  localparam int BUS_W  = 8;

  typedef enum logic {
    LOAD_BYTE = 1'b0,
    LOAD_BIT  = 1'b1
  } load_mode_e;
endpackage

// File: rtl/dds_rise_det.sv
module dds_rise_det (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise
);
  logic lvl_q;

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= 1'b0;
    else     lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;
endmodule

// File: rtl/dds_load_sreg.sv
module dds_load_sreg
  import dds_core_pkg::*;
#(
  parameter int WORD_W     = 40,
  parameter int BUS_W_P    = 8,
  parameter bit HAS_SERIAL = 1'b1
) (
  input  logic               clk,
  input  logic               shift_en,
  input  load_mode_e         mode,
  input  logic [BUS_W_P-1:0] din,
  output logic [WORD_W-1:0]  word_o
);
  logic [WORD_W-1:0] sreg_q;
  logic [WORD_W-1:0] sreg_d;
  logic [WORD_W-1:0] by_byte;

  // new data enters at the top, older content moves toward the LSB
  assign by_byte = {din, sreg_q[WORD_W-1:BUS_W_P]};

  generate
    if (HAS_SERIAL) begin : g_dual
      logic [WORD_W-1:0] by_bit;
      assign by_bit = {din[0], sreg_q[WORD_W-1:1]};
      assign sreg_d = (mode == LOAD_BIT) ? by_bit : by_byte;
    end else begin : g_byte_only
      assign sreg_d = by_byte;
    end
  endgenerate

  // deliberately no reset: contents survive a core reset
  always_ff @(posedge clk) begin
    if (shift_en) sreg_q <= sreg_d;
  end

  assign word_o = sreg_q;
endmodule

// File: rtl/dds_work_reg.sv
module dds_work_reg #(
  parameter int WORD_W = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] d,
  output logic [WORD_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
  parameter int ACC_W = 32,
  parameter int OFF_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACC_W-1:0] ftw,
  input  logic [OFF_W-1:0] off,
  output logic [ACC_W-1:0] acc_o,
  output logic [ACC_W-1:0] phase_o
);
  localparam int LOW_W = ACC_W - OFF_W;

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] phase_q;
  logic [OFF_W-1:0] top_sum;

  assign top_sum = acc_q[ACC_W-1 -: OFF_W] + off;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      phase_q <= '0;
    end else begin
      acc_q   <= acc_q + ftw;
      phase_q <= {top_sum, acc_q[LOW_W-1:0]};
    end
  end

  assign acc_o   = acc_q;
  assign phase_o = phase_q;

  // R1: one edge after reset the accumulator and output are both zero
  a_r1_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (acc_q == '0 && phase_q == '0));
endmodule

// File: rtl/dds_phase_core.sv
module dds_phase_core
  import dds_core_pkg::*;
#(
  parameter int P_FTW_W  = FTW_W,
  parameter int P_OFF_W  = OFF_W,
  parameter int P_CTRL_W = CTRL_W,
  parameter int P_BUS_W  = BUS_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_stb,
  input  logic               load_sel,
  input  logic [P_BUS_W-1:0] din,
  input  logic               upd_stb,
  output logic [P_FTW_W-1:0] phase_out
);
  localparam int WORD_W = P_FTW_W + P_CTRL_W + P_OFF_W;

  logic               wr_rise;
  logic               upd_rise;
  load_mode_e         mode;
  logic [WORD_W-1:0]  sreg_q;
  logic [WORD_W-1:0]  work_q;
  logic [P_FTW_W-1:0] acc_q;
  logic [P_FTW_W-1:0] ftw_w;
  logic [P_OFF_W-1:0] off_w;

  assign mode  = load_mode_e'(load_sel);
  assign ftw_w = work_q[P_FTW_W-1:0];
  assign off_w = work_q[WORD_W-1 -: P_OFF_W];

  dds_rise_det u_wr_edge (
    .clk  (clk),
    .rst  (rst),
    .lvl  (wr_stb),
    .rise (wr_rise)
  );

  dds_rise_det u_upd_edge (
    .clk  (clk),
    .rst  (rst),
    .lvl  (upd_stb),
    .rise (upd_rise)
  );

  dds_load_sreg #(
    .WORD_W     (WORD_W),
    .BUS_W_P    (P_BUS_W),
    .HAS_SERIAL (1'b1)
  ) u_sreg (
    .clk      (clk),
    .shift_en (wr_rise),
    .mode     (mode),
    .din      (din),
    .word_o   (sreg_q)
  );

  dds_work_reg #(
    .WORD_W (WORD_W)
  ) u_work (
    .clk  (clk),
    .rst  (rst),
    .load (upd_rise),
    .d    (sreg_q),
    .q    (work_q)
  );

  dds_phase_acc #(
    .ACC_W (P_FTW_W),
    .OFF_W (P_OFF_W)
  ) u_acc (
    .clk     (clk),
    .rst     (rst),
    .ftw     (ftw_w),
    .off     (off_w),
    .acc_o   (acc_q),
    .phase_o (phase_out)
  );

  // R4: a write strobe already high on the previous edge causes no shift
  a_r4_single_shift: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && $past(wr_stb) && !$past(rst)) |=> $stable(sreg_q));

  // R5: an update edge copies the staged word into the working register
  a_r5_transfer: assert property (@(posedge clk) disable iff (rst)
    upd_rise |=> (work_q == $past(sreg_q)));

  // R6: a held update strobe freezes the working register
  a_r6_held_update: assert property (@(posedge clk) disable iff (rst)
    (upd_stb && $past(upd_stb) && !$past(rst)) |=> $stable(work_q));

  // R8: the output follows the accumulator with the offset on its top bits
  a_r8_offset_add: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |->
      (phase_out[P_FTW_W-P_OFF_W-1:0] == $past(acc_q[P_FTW_W-P_OFF_W-1:0]) &&
       phase_out[P_FTW_W-1 -: P_OFF_W] ==
         P_OFF_W'($past(acc_q[P_FTW_W-1 -: P_OFF_W]) + $past(off_w))));
endmodule

// File: tb/test_dds_phase_core.sv
module test_dds_phase_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_stb = 1'b0;
  logic        load_sel = 1'b0;
  logic [7:0]  din = 8'h00;
  logic        upd_stb = 1'b0;
  logic [31:0] phase_out;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  int u_cnt = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dds_phase_core i_dds_phase_core (
    .clk       (clk),
    .rst       (rst),
    .wr_stb    (wr_stb),
    .load_sel  (load_sel),
    .din       (din),
    .upd_stb   (upd_stb),
    .phase_out (phase_out)
  );

  localparam int NV = 6;
  localparam logic [31:0] V_FTW [NV] = '{32'h0000_0001, 32'h1234_5678, 32'h8000_0000,
                                        32'hF800_0000, 32'h00AB_CDEF, 32'h4000_0000};
  localparam logic [4:0]  V_OFF [NV] = '{5'd0, 5'd3, 5'd0, 5'd5, 5'd31, 5'd16};
  localparam logic [2:0]  V_CTL [NV] = '{3'd0, 3'd0, 3'd0, 3'd0, 3'd7, 3'd5};
  localparam bit          V_SER [NV] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0};
  localparam int          V_N   [NV] = '{5, 4, 4, 3, 6, 2};

  function automatic logic [31:0] exp_phase(input logic [31:0] acc, input logic [4:0] off);
    logic [4:0] top;
    top = acc[31:27] + off;
    return {top, acc[26:0]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic write_unit(input logic [7:0] d, input int hold);
    @(negedge clk);
    wr_stb = 1'b1;
    din = d;
    repeat (hold) @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic load_word(input logic [39:0] w, input bit ser, input int hold);
    load_sel = ser;
    if (ser) begin
      for (int b = 0; b < 40; b++) write_unit({7'h5A, w[b]}, hold);
    end else begin
      for (int k = 0; k < 5; k++) write_unit(w[8*k +: 8], hold);
    end
  endtask

  task automatic pulse_update();
    @(negedge clk);
    upd_stb = 1'b1;
    u_cnt = cyc + 1;
    @(negedge clk);
    upd_stb = 1'b0;
  endtask

  task automatic wait_edges(input int n);
    while (cyc - u_cnt < n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [39:0] w1, w2;
    logic [31:0] acc_v;
    int u1, d;

    // R1: reset state and idle after reset
    do_reset();
    check("R1 reset", phase_out, 32'h0);
    repeat (5) @(negedge clk);
    check("R1 idle after reset", phase_out, 32'h0);

    // R2 R3 R7 R8 R10: vector table
    for (int i = 0; i < NV; i++) begin
      do_reset();
      load_word({V_OFF[i], V_CTL[i], V_FTW[i]}, V_SER[i], 1);
      pulse_update();
      wait_edges(V_N[i]);
      acc_v = V_FTW[i] * 32'(V_N[i] - 1);
      check(V_SER[i] ? "R3 R7 R8 R10 bit-mode vector" : "R2 R7 R8 R10 byte-mode vector",
            phase_out, exp_phase(acc_v, V_OFF[i]));
    end

    // R9: staged word survives reset
    do_reset();
    load_sel = 1'b0;
    w1 = {5'd9, 3'd0, 32'h0300_0001};
    load_word(w1, 1'b0, 1);
    do_reset();
    pulse_update();
    wait_edges(3);
    check("R9 staging kept over reset", phase_out, exp_phase(32'h0600_0002, 5'd9));

    // R4: held write strobe shifts once
    do_reset();
    w1 = {5'd2, 3'd1, 32'h0101_0101};
    load_word(w1, 1'b0, 3);
    pulse_update();
    wait_edges(4);
    check("R4 held write strobe", phase_out, exp_phase(32'h0303_0303, 5'd2));

    // R6: held update strobe, writes during the hold
    do_reset();
    w1 = {5'd1, 3'd0, 32'h0010_0000};
    w2 = {5'd20, 3'd0, 32'h0700_0000};
    load_word(w1, 1'b0, 1);
    @(negedge clk);
    upd_stb = 1'b1;
    u1 = cyc + 1;
    u_cnt = u1;
    load_word(w2, 1'b0, 1);
    @(negedge clk);
    d = cyc - u1;
    check("R6 held update keeps first word", phase_out,
          exp_phase(32'h0010_0000 * 32'(d - 1), 5'd1));
    upd_stb = 1'b0;

    // R11: staged but not updated, output keeps first slope
    repeat (4) @(negedge clk);
    d = cyc - u1;
    check("R11 no update no change", phase_out,
          exp_phase(32'h0010_0000 * 32'(d - 1), 5'd1));

    // R5: second update switches slope and offset
    pulse_update();
    d = u_cnt - u1;
    wait_edges(1);
    check("R5 offset on first edge", phase_out,
          exp_phase(32'h0010_0000 * 32'(d), 5'd20));
    wait_edges(4);
    check("R5 new step after update", phase_out,
          exp_phase(32'h0010_0000 * 32'(d) + 32'h0700_0000 * 32'd3, 5'd20));

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule